// File: doc/BRIEF.md
# Triple-Voted Over-Temperature Interlock Latch

This block protects one side of a half-stave. It watches the temperature of up to 24 hybrid sensors and drives one interlock line. The readings arrive one at a time from a shared 12-bit converter. Each reading is a code with a channel index and a valid strobe. Every valid reading is compared against a single over-heat threshold code.

The sensors have a negative temperature coefficient, so a hotter hybrid gives a lower code. A channel counts as over-heated when its code is at or below the threshold. Any such reading latches the interlock, provided the block is armed. The interlock then holds until software pulses the clear input.

The threshold and the arm bit are each held in three copies. Reads go through a majority vote. The voted value is written back into all three copies on every clock, so a single upset copy is repaired. A sticky flag per channel and a record of the first channel that tripped let the cause be read back after the event.

Top module: `ot_interlock_latch`

## Requirements
- R1: After reset, interlock is 0, all trip_flags are 0 and first_vld is 0. The stored threshold code is 0 and the block is disarmed.
- R2: A reading trips when it meets all of these: smp_vld is 1, smp_chan is below NCH, the block is armed, and smp_code is at or below the threshold (a code one above the threshold does not trip). A trip sets interlock at the clock edge that samples the reading.
- R3: The threshold is stored in three majority-voted copies that are rewritten every clock. A thr_we write applies from the following cycle; a reading taken in the write cycle itself is compared with the previous threshold.
- R4: The arm bit is stored in three majority-voted copies that are rewritten every clock. While it is 0, no reading trips. An arm_we write applies from the following cycle.
- R5: Once set, interlock and the trip flags stay set through any number of cool or invalid readings until clr is applied.
- R6: clr applied with no trip in the same cycle returns interlock, trip_flags and first_vld to 0 at that edge.
- R7: When clr and a trip fall in the same cycle, interlock stays 1. Only the tripping channel's flag remains set, and first_chan names that channel.
- R8: Bit i of trip_flags is set by a trip on channel i, and flags of different channels accumulate.
- R9: The first trip after reset or clear sets first_vld and records its channel in first_chan. Later trips leave first_chan unchanged until clr.
- R10: A reading with smp_chan of NCH or more never trips and changes no output.
- R11: A reading with smp_vld at 0 never trips, whatever its code and channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_vld | input | 1 | Reading strobe |
| smp_chan | input | 5 | Channel index of the reading |
| smp_code | input | 12 | Converter code of the reading |
| thr_we | input | 1 | Threshold write strobe |
| thr_wdata | input | 12 | New threshold code |
| arm_we | input | 1 | Arm bit write strobe |
| arm_wdata | input | 1 | New arm bit value |
| clr | input | 1 | Clear of interlock, flags and first-trip record |
| interlock | output | 1 | Latched interlock |
| trip_flags | output | 24 | Sticky per-channel trip flags |
| first_chan | output | 5 | Channel of the first trip since clear |
| first_vld | output | 1 | first_chan holds a valid channel |

## Verification
A trip and a clear can land on the same clock edge. So can a threshold write and a reading that the old threshold would trip. The bench drives both pairs on purpose. It first trips one channel and then, in a single cycle, applies clr together with a hot reading on another channel. The scoreboard expects interlock still high, only the new channel's flag set, and first_chan naming it. For the write pair, it writes a lower threshold in the same cycle as a reading that trips only against the old value. It expects the trip, then checks that a repeat of that reading after a clear no longer trips.

// File: rtl/oti_pkg.sv
package oti_pkg;

  localparam int unsigned OTI_COPIES = 3;

  // Bitwise two-out-of-three majority.
  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/oti_rst_sync.sv
module oti_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sn = sync_q[STAGES-1];

endmodule

// File: rtl/oti_tmr_reg.sv
module oti_tmr_reg #(
  parameter int unsigned W = 12,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  import oti_pkg::*;

  logic [W-1:0] copy_q [OTI_COPIES];
  logic [W-1:0] voted;
  logic [W-1:0] nxt;

  // Majority vote, one voter per bit.
  for (genvar b = 0; b < int'(W); b++) begin : g_vote
    assign voted[b] = vote3(copy_q[0][b], copy_q[1][b], copy_q[2][b]);
  end

  // Next state: a write wins; otherwise the voted value is scrubbed back.
  always_comb begin
    nxt = we ? wdata : voted;
  end

  for (genvar c = 0; c < int'(OTI_COPIES); c++) begin : g_copy
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        copy_q[c] <= RST_VAL;
      end else begin
        copy_q[c] <= nxt;
      end
    end
  end

  assign q = voted;

  // R3/R4: a write is visible through the voter in the next cycle.
  p_write_visible_r3: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (q == $past(wdata)));

  // R3/R4: without a write the voted value does not drift.
  p_hold_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));

endmodule

// File: rtl/oti_trip_eval.sv
module oti_trip_eval #(
  parameter int unsigned NCH = 24,
  parameter int unsigned CW  = 12,
  parameter int unsigned IW  = 5
) (
  input  logic           smp_vld,
  input  logic [IW-1:0]  smp_chan,
  input  logic [CW-1:0]  smp_code,
  input  logic [CW-1:0]  thr,
  input  logic           armed,
  output logic [NCH-1:0] hit
);

  logic hot;

  // Hotter sensor gives lower code: at or below threshold is over-heat.
  always_comb begin
    hot = smp_vld && armed && (smp_code <= thr);
  end

  for (genvar i = 0; i < int'(NCH); i++) begin : g_chan
    assign hit[i] = hot && (smp_chan == IW'(i));
  end

endmodule

// File: rtl/oti_flag_bank.sv
module oti_flag_bank #(
  parameter int unsigned NCH = 24,
  parameter int unsigned IW  = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic [NCH-1:0] hit,
  output logic [NCH-1:0] flags,
  output logic           latch,
  output logic           first_vld,
  output logic [IW-1:0]  first_chan
);

  logic [NCH-1:0] flags_q, flags_d;
  logic           latch_q, latch_d;
  logic           fv_q, fv_d;
  logic [IW-1:0]  fc_q, fc_d;
  logic           any_hit;
  logic           upd;
  logic [IW-1:0]  hit_idx;

  always_comb begin
    hit_idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (hit[i]) hit_idx = IW'(i);
    end
  end

  always_comb begin
    any_hit = |hit;
    upd     = clr | any_hit;
    flags_d = (clr ? '0 : flags_q) | hit;
    latch_d = (clr ? 1'b0 : latch_q) | any_hit;
    fv_d    = clr ? 1'b0 : fv_q;
    fc_d    = fc_q;
    if (!fv_d && any_hit) begin
      fv_d = 1'b1;
      fc_d = hit_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      latch_q <= 1'b0;
      fv_q    <= 1'b0;
      fc_q    <= '0;
    end else if (upd) begin
      flags_q <= flags_d;
      latch_q <= latch_d;
      fv_q    <= fv_d;
      fc_q    <= fc_d;
    end
  end

  assign flags      = flags_q;
  assign latch      = latch_q;
  assign first_vld  = fv_q;
  assign first_chan = fc_q;

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    latch_q && !clr |=> latch_q);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !(|hit) |=> !latch_q && (flags_q == '0) && !fv_q);

  p_clr_trip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr && (|hit) |=> latch_q && fv_q);

  p_first_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fv_q && !clr |=> fv_q && $stable(fc_q));

  p_one_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

endmodule

// File: rtl/ot_interlock_latch.sv
module ot_interlock_latch #(
  parameter int unsigned NCH = 24,
  parameter int unsigned CW  = 12,
  localparam int unsigned IW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           smp_vld,
  input  logic [IW-1:0]  smp_chan,
  input  logic [CW-1:0]  smp_code,
  input  logic           thr_we,
  input  logic [CW-1:0]  thr_wdata,
  input  logic           arm_we,
  input  logic           arm_wdata,
  input  logic           clr,
  output logic           interlock,
  output logic [NCH-1:0] trip_flags,
  output logic [IW-1:0]  first_chan,
  output logic           first_vld
);

  logic           rst_sn;
  logic [CW-1:0]  thr_v;
  logic [0:0]     arm_v;
  logic [NCH-1:0] hit;

  oti_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  oti_tmr_reg #(.W(CW), .RST_VAL('0)) u_thr (
    .clk   (clk),
    .rst_n (rst_sn),
    .we    (thr_we),
    .wdata (thr_wdata),
    .q     (thr_v)
  );

  oti_tmr_reg #(.W(1), .RST_VAL(1'b0)) u_arm (
    .clk   (clk),
    .rst_n (rst_sn),
    .we    (arm_we),
    .wdata (arm_wdata),
    .q     (arm_v)
  );

  oti_trip_eval #(.NCH(NCH), .CW(CW), .IW(IW)) u_eval (
    .smp_vld  (smp_vld),
    .smp_chan (smp_chan),
    .smp_code (smp_code),
    .thr      (thr_v),
    .armed    (arm_v[0]),
    .hit      (hit)
  );

  oti_flag_bank #(.NCH(NCH), .IW(IW)) u_flags (
    .clk        (clk),
    .rst_n      (rst_sn),
    .clr        (clr),
    .hit        (hit),
    .flags      (trip_flags),
    .latch      (interlock),
    .first_vld  (first_vld),
    .first_chan (first_chan)
  );

  p_disarmed_r4: assert property (@(posedge clk) disable iff (!rst_sn)
    !arm_v[0] && !interlock && !clr |=> !interlock);

  p_range_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    (int'(smp_chan) >= int'(NCH)) && !clr |=> $stable(trip_flags) && $stable(interlock));

  p_novld_r11: assert property (@(posedge clk) disable iff (!rst_sn)
    !smp_vld && !clr |=> $stable(trip_flags) && $stable(interlock));

  p_flags_vs_latch_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    interlock == (|trip_flags));

endmodule

// File: tb/tb_ot_interlock_latch.sv
module tb_ot_interlock_latch;

  localparam int NCH = 24;
  localparam int CW  = 12;
  localparam int IW  = 5;
  localparam time CLK_PERIOD = 10ns;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           smp_vld;
  logic [IW-1:0]  smp_chan;
  logic [CW-1:0]  smp_code;
  logic           thr_we;
  logic [CW-1:0]  thr_wdata;
  logic           arm_we;
  logic           arm_wdata;
  logic           clr;
  logic           interlock;
  logic [NCH-1:0] trip_flags;
  logic [IW-1:0]  first_chan;
  logic           first_vld;

  always #(CLK_PERIOD/2) clk = ~clk;

  ot_interlock_latch #(.NCH(NCH), .CW(CW)) dut (
    .clk, .rst_n, .smp_vld, .smp_chan, .smp_code, .thr_we, .thr_wdata,
    .arm_we, .arm_wdata, .clr, .interlock, .trip_flags, .first_chan, .first_vld
  );

  typedef struct {
    logic           il;
    logic [NCH-1:0] fl;
    logic           fv;
    logic [IW-1:0]  fc;
    string          tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;

  // Requirement-level model state.
  logic [CW-1:0]  m_thr;
  logic           m_arm;
  logic           m_il;
  logic [NCH-1:0] m_fl;
  logic           m_fv;
  logic [IW-1:0]  m_fc;

  task automatic step(input logic vld, input int ch, input int code,
                      input logic twe, input int twd,
                      input logic awe, input logic awd,
                      input logic c, input string tag);
    logic trip;
    exp_t e;
    @(negedge clk);
    smp_vld = vld; smp_chan = IW'(ch); smp_code = CW'(code);
    thr_we = twe; thr_wdata = CW'(twd);
    arm_we = awe; arm_wdata = awd; clr = c;
    trip = vld && (ch < NCH) && m_arm && (CW'(code) <= m_thr);
    if (c) begin m_il = 0; m_fl = '0; m_fv = 0; end
    if (trip) begin
      m_il = 1; m_fl[ch] = 1'b1;
      if (!m_fv) begin m_fv = 1; m_fc = IW'(ch); end
    end
    if (twe) m_thr = CW'(twd);
    if (awe) m_arm = awd;
    @(posedge clk);
    #1;
    e.il = m_il; e.fl = m_fl; e.fv = m_fv; e.fc = m_fc; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: pops one expected item per cycle and compares.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (interlock !== e.il || trip_flags !== e.fl || first_vld !== e.fv ||
          (e.fv && first_chan !== e.fc)) begin
        errors++;
        $display("FAIL %s: got il=%0b fl=%h fv=%0b fc=%0d, expected il=%0b fl=%h fv=%0b fc=%0d",
                 e.tag, interlock, trip_flags, first_vld, first_chan,
                 e.il, e.fl, e.fv, e.fc);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; smp_vld = 0; smp_chan = '0; smp_code = '0;
    thr_we = 0; thr_wdata = '0; arm_we = 0; arm_wdata = 0; clr = 0;
    m_thr = '0; m_arm = 0; m_il = 0; m_fl = '0; m_fv = 0; m_fc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (interlock !== 1'b0 || trip_flags !== '0 || first_vld !== 1'b0) begin
      errors++;
      $display("FAIL R1: got il=%0b fl=%h fv=%0b, expected 0 0 0",
               interlock, trip_flags, first_vld);
    end

    // R1: disarmed with threshold 0, a zero code must not trip.
    step(1, 4, 0, 0, 0, 0, 0, 0, "R1 disarmed at reset");
    step(0, 0, 0, 0, 0, 1, 1, 0, "R4 arm write");
    // R1: threshold 0 now armed; code 1 is above it.
    step(1, 2, 1, 0, 0, 0, 0, 0, "R1 threshold zero");
    step(0, 0, 0, 1, 12'h400, 0, 0, 0, "R3 threshold write");
    step(1, 3, 12'h401, 0, 0, 0, 0, 0, "R2 one above threshold");
    step(1, 3, 12'h400, 0, 0, 0, 0, 0, "R2 equal to threshold trips");
    step(1, 7, 12'h100, 0, 0, 0, 0, 0, "R8 R9 second channel");
    step(1, 7, 12'hFFF, 0, 0, 0, 0, 0, "R5 sticky cool reading");
    step(0, 9, 0, 0, 0, 0, 0, 0, "R5 sticky idle");
    step(0, 0, 0, 0, 0, 0, 0, 1, "R6 clear");
    step(1, 5, 12'h300, 1, 12'h200, 0, 0, 0, "R3 write cycle uses old");
    step(0, 0, 0, 0, 0, 0, 0, 1, "R6 clear again");
    step(1, 5, 12'h300, 0, 0, 0, 0, 0, "R3 new threshold applies");
    step(1, 24, 0, 0, 0, 0, 0, 0, "R10 index equal NCH");
    step(1, 31, 0, 0, 0, 0, 0, 0, "R10 index max");
    step(0, 2, 0, 0, 0, 0, 0, 0, "R11 no strobe");
    step(0, 0, 0, 0, 0, 1, 0, 0, "R4 disarm write");
    step(1, 1, 0, 0, 0, 0, 0, 0, "R4 disarmed no trip");
    step(1, 1, 0, 0, 0, 1, 1, 0, "R4 arm write cycle still disarmed");
    step(1, 9, 12'h050, 0, 0, 0, 0, 0, "R2 trip after rearm");
    step(1, 12, 0, 0, 0, 0, 0, 1, "R7 clear with trip");
    step(1, 12, 12'hFFF, 0, 0, 0, 0, 0, "R7 held after");
    step(0, 0, 0, 0, 0, 0, 0, 1, "R6 clear third");
    step(1, 23, 12'h1FF, 0, 0, 0, 0, 0, "R8 top channel");
    step(1, 0, 0, 0, 0, 0, 0, 0, "R9 first kept");
    step(0, 0, 0, 0, 0, 0, 0, 1, "R6 final clear");
    step(1, 0, 12'h200, 0, 0, 0, 0, 0, "R9 channel zero first");

    @(negedge clk);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule